// File: doc/BRIEF.md
# Gate Drive Protection Sequencer

This block is the clocked control core that sits between a motor-control PWM generator and the gate drivers of a three-phase bridge with one extra boost (PFC) switch. It turns six inverter commands and one PFC command into seven gate-enable outputs. Along the way it applies the interlocks a power stage needs: a phase never has both switches on, over-current trips are filtered and then shut everything down, supply and bootstrap undervoltage are honoured, and an external enable can halt all switching.

An accepted over-current event raises an open-drain pull-down request that is held for a fixed number of clock cycles after the last cycle with an accepted trip, and then drops by itself. Since the same board pin serves as the enable input, the block's own fault also holds its outputs off. After reset, and after every supply undervoltage, each phase keeps its high-side switch off until a low-side command has been seen on that phase. This gives the bootstrap capacitor a chance to charge before the high side is used.

Every output is registered. A change on the inputs therefore reaches the outputs on the clock edge that follows the edge where it is sampled. The blanking length and the fault pulse length are parameters counted in clock cycles.

Top module: `gate_prot_seq`

## Requirements
- R1: When `hi_cmd[i]` and `lo_cmd[i]` are both 1, `hi_gate[i]` and `lo_gate[i]` are both 0 one cycle later.
- R2: Outputs follow commands one cycle later when nothing blocks them. `lo_cmd[i]` alone gives `lo_gate[i]`=1. `hi_cmd[i]` alone gives `hi_gate[i]`=1 on an armed phase. `pfc_gate` follows `pfc_cmd`.
- R3: An accepted trip on `oc_inv` or on `oc_pfc` forces all seven gate outputs to 0 and sets `fault_pd`=1 on the next edge, whatever the commands are.
- R4: A trip flag is accepted only once it has been sampled high on BLANK_CYC consecutive edges. A flag that is high for fewer edges changes no output.
- R5: `fault_pd` and the gate blocking stay active for PULSE_CYC cycles after the last cycle with an accepted trip. A trip that arrives during the pulse restarts the count. Once the pulse ends, both release on their own.
- R6: While `uv_supply`=1, all gate outputs are 0 and `fault_pd`=1 one cycle later. Both release once it clears, unless a fault pulse is still running.
- R7: `uv_boot[i]`=1 forces only `hi_gate[i]` to 0. It does not set `fault_pd` and has no effect on other outputs.
- R8: After reset, and after any cycle with `uv_supply`=1, `hi_gate[i]` stays 0 until `lo_cmd[i]` has been sampled 1 while `uv_supply`=0.
- R9: `en_pin`=0 forces all gate outputs to 0 one cycle later and does not by itself set `fault_pd`.
- R10: During and directly after reset, all gate outputs and `fault_pd` are 0, and every phase waits for a low-side command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | NPH | High-side command per phase |
| lo_cmd | input | NPH | Low-side command per phase |
| pfc_cmd | input | 1 | PFC switch command |
| oc_inv | input | 1 | Synchronized inverter over-current flag |
| oc_pfc | input | 1 | Synchronized PFC over-current flag |
| uv_supply | input | 1 | Driver supply undervoltage flag |
| uv_boot | input | NPH | High-side bias undervoltage flag per phase |
| en_pin | input | 1 | Sampled level of the shared fault/enable pin |
| hi_gate | output | NPH | High-side gate enable per phase |
| lo_gate | output | NPH | Low-side gate enable per phase |
| pfc_gate | output | 1 | PFC gate enable |
| fault_pd | output | 1 | Open-drain pull-down request for the fault/enable pin |

## Verification
The hardest situation to reach is a second accepted trip that lands while a fault pulse is already counting down. The bench has to hold a flag high for past the blanking length in the middle of a pulse, then show that the release moves out by a full pulse from the new trip rather than from the first one. Directed stimulus sets this up with short parameter values. A long random phase then mixes short glitches, longer bursts, undervoltage episodes and enable drops against a cycle-by-cycle behavioural model, so the trip timing lands at many different points inside the pulse.

// File: rtl/gps_pkg.sv
package gps_pkg;
  typedef enum logic {
    ARM_WAIT  = 1'b0,
    ARM_READY = 1'b1
  } arm_e;
endpackage

// File: rtl/gps_trip_blank.sv
module gps_trip_blank #(
  parameter int BLANK_CYC = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  output logic trip
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(BLANK_CYC);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= '0;
    else if (!flag)          run_cnt <= '0;
    else if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
  end

  assign trip = (run_cnt == FULL);

  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (rst)
    !flag |=> !trip); // R4
endmodule

// File: rtl/gps_fault_timer.sv
module gps_fault_timer #(
  parameter int PULSE_CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_any,
  output logic active
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(PULSE_CYC);

  logic [CW-1:0] left_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 left_cnt <= '0;
    else if (trip_any)       left_cnt <= FULL;
    else if (left_cnt != '0) left_cnt <= left_cnt - 1'b1;
  end

  assign active = (left_cnt != '0);

  AST_PULSE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    trip_any |=> active); // R5
  AST_PULSE_STAYS_OFF: assert property (@(posedge clk) disable iff (rst)
    (!trip_any && !active) |=> !active); // R5
endmodule

// File: rtl/gps_phase_gate.sv
module gps_phase_gate
  import gps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hi_cmd,
  input  logic lo_cmd,
  input  logic kill,
  input  logic uv_supply,
  input  logic uv_boot,
  output logic hi_gate,
  output logic lo_gate
);
  arm_e arm;

  always_ff @(posedge clk) begin
    if (rst)            arm <= ARM_WAIT;
    else if (uv_supply) arm <= ARM_WAIT;
    else if (lo_cmd)    arm <= ARM_READY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_gate <= 1'b0;
      lo_gate <= 1'b0;
    end else begin
      hi_gate <= !kill && hi_cmd && !lo_cmd && (arm == ARM_READY) && !uv_boot;
      lo_gate <= !kill && lo_cmd && !hi_cmd;
    end
  end

  AST_NO_DUAL_ON: assert property (@(posedge clk) disable iff (rst)
    (hi_cmd && lo_cmd) |=> (!hi_gate && !lo_gate)); // R1
  AST_BOOT_UV_HI_OFF: assert property (@(posedge clk) disable iff (rst)
    uv_boot |=> !hi_gate); // R7
  AST_WAIT_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    (arm == ARM_WAIT) |=> !hi_gate); // R8
  AST_UV_DISARM: assert property (@(posedge clk) disable iff (rst)
    uv_supply |=> (arm == ARM_WAIT)); // R8
endmodule

// File: rtl/gate_prot_seq.sv
module gate_prot_seq #(
  parameter int NPH       = 3,
  parameter int BLANK_CYC = 18,
  parameter int PULSE_CYC = 100000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] hi_cmd,
  input  logic [NPH-1:0] lo_cmd,
  input  logic           pfc_cmd,
  input  logic           oc_inv,
  input  logic           oc_pfc,
  input  logic           uv_supply,
  input  logic [NPH-1:0] uv_boot,
  input  logic           en_pin,
  output logic [NPH-1:0] hi_gate,
  output logic [NPH-1:0] lo_gate,
  output logic           pfc_gate,
  output logic           fault_pd
);
  localparam int NTRIP = 2;

  logic [NTRIP-1:0] oc_vec;
  logic [NTRIP-1:0] trip_vec;
  logic             trip_any;
  logic             pulse_act;
  logic             kill;

  assign oc_vec = {oc_pfc, oc_inv};

  for (genvar t = 0; t < NTRIP; t++) begin : g_trip
    gps_trip_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk  (clk),
      .rst  (rst),
      .flag (oc_vec[t]),
      .trip (trip_vec[t])
    );
  end

  assign trip_any = |trip_vec;

  gps_fault_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .trip_any (trip_any),
    .active   (pulse_act)
  );

  assign kill = trip_any || pulse_act || uv_supply || !en_pin;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    gps_phase_gate u_phase (
      .clk       (clk),
      .rst       (rst),
      .hi_cmd    (hi_cmd[p]),
      .lo_cmd    (lo_cmd[p]),
      .kill      (kill),
      .uv_supply (uv_supply),
      .uv_boot   (uv_boot[p]),
      .hi_gate   (hi_gate[p]),
      .lo_gate   (lo_gate[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pfc_gate <= 1'b0;
      fault_pd <= 1'b0;
    end else begin
      pfc_gate <= !kill && pfc_cmd;
      fault_pd <= trip_any || pulse_act || uv_supply;
    end
  end

  AST_TRIP_SHUTS: assert property (@(posedge clk) disable iff (rst)
    trip_any |=> (fault_pd && hi_gate == '0 && lo_gate == '0 && !pfc_gate)); // R3
  AST_SUPPLY_UV: assert property (@(posedge clk) disable iff (rst)
    uv_supply |=> (fault_pd && hi_gate == '0 && lo_gate == '0 && !pfc_gate)); // R6
  AST_EN_LOW: assert property (@(posedge clk) disable iff (rst)
    !en_pin |=> (hi_gate == '0 && lo_gate == '0 && !pfc_gate)); // R9
  AST_EN_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (!trip_any && !pulse_act && !uv_supply) |=> !fault_pd); // R9
endmodule

// File: tb/gate_prot_seq_test.sv
module gate_prot_seq_test;
  localparam int NPH = 3;
  localparam int BLK = 4;
  localparam int PUL = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPH-1:0] hi_cmd = '0, lo_cmd = '0, uv_boot = '0;
  logic pfc_cmd = 1'b0, oc_inv = 1'b0, oc_pfc = 1'b0, uv_supply = 1'b0, en_pin = 1'b1;
  logic [NPH-1:0] hi_gate, lo_gate;
  logic pfc_gate, fault_pd;

  int n_cmp = 0, n_bad = 0;
  bit live = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  gate_prot_seq #(.NPH(NPH), .BLANK_CYC(BLK), .PULSE_CYC(PUL)) uut (
    .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .pfc_cmd(pfc_cmd),
    .oc_inv(oc_inv), .oc_pfc(oc_pfc), .uv_supply(uv_supply), .uv_boot(uv_boot),
    .en_pin(en_pin), .hi_gate(hi_gate), .lo_gate(lo_gate), .pfc_gate(pfc_gate),
    .fault_pd(fault_pd)
  );

  // behavioural reference
  int run_i = 0, run_p = 0, left = 0;
  logic [NPH-1:0] armed = '0, e_hi = '0, e_lo = '0;
  logic e_pfc = 1'b0, e_flt = 1'b0;

  always @(posedge clk) begin : model
    bit tr, blocked;
    if (rst) begin
      run_i <= 0; run_p <= 0; left <= 0; armed <= '0;
      e_hi <= '0; e_lo <= '0; e_pfc <= 1'b0; e_flt <= 1'b0;
    end else begin
      tr = (run_i == BLK) || (run_p == BLK);
      blocked = tr || (left > 0) || uv_supply || !en_pin;
      run_i <= oc_inv ? ((run_i < BLK) ? run_i + 1 : BLK) : 0;
      run_p <= oc_pfc ? ((run_p < BLK) ? run_p + 1 : BLK) : 0;
      left  <= tr ? PUL : ((left > 0) ? left - 1 : 0);
      for (int i = 0; i < NPH; i++) begin
        e_hi[i] <= !blocked && hi_cmd[i] && !lo_cmd[i] && armed[i] && !uv_boot[i];
        e_lo[i] <= !blocked && lo_cmd[i] && !hi_cmd[i];
        if (uv_supply) armed[i] <= 1'b0;
        else if (lo_cmd[i]) armed[i] <= 1'b1;
      end
      e_pfc <= !blocked && pfc_cmd;
      e_flt <= tr || (left > 0) || uv_supply;
    end
  end

  task automatic cmp(string req, logic [NPH-1:0] act, logic [NPH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      cmp("R1 R2 R7 R8 hi_gate model", hi_gate, e_hi);
      cmp("R1 R2 R9 lo_gate model", lo_gate, e_lo);
      cmp("R2 R3 R6 pfc_gate model", {2'b00, pfc_gate}, {2'b00, e_pfc});
      cmp("R3 R4 R5 R6 fault_pd model", {2'b00, fault_pd}, {2'b00, e_flt});
    end
  end

  task automatic chk(string req, logic [NPH-1:0] eh, logic [NPH-1:0] el, logic ep, logic ef);
    cmp({req, " hi"}, hi_gate, eh);
    cmp({req, " lo"}, lo_gate, el);
    cmp({req, " pfc/fault"}, {1'b0, pfc_gate, fault_pd}, {1'b0, ep, ef});
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int burst_i, burst_p, burst_u;
    cyc(3);
    chk("R10 in reset", 3'b000, 3'b000, 1'b0, 1'b0);
    rst = 1'b0; live = 1'b1;
    cyc(1);
    chk("R10 after reset", 3'b000, 3'b000, 1'b0, 1'b0);
    hi_cmd = 3'b111; cyc(3);
    chk("R8 unarmed high", 3'b000, 3'b000, 1'b0, 1'b0);
    hi_cmd = 3'b000; lo_cmd = 3'b111; pfc_cmd = 1'b1; cyc(2);
    chk("R2 low only", 3'b000, 3'b111, 1'b1, 1'b0);
    hi_cmd = 3'b111; lo_cmd = 3'b000; cyc(2);
    chk("R2 high only", 3'b111, 3'b000, 1'b1, 1'b0);
    lo_cmd = 3'b111; cyc(2);
    chk("R1 both", 3'b000, 3'b000, 1'b1, 1'b0);
    lo_cmd = 3'b000; oc_inv = 1'b1; cyc(BLK - 1); oc_inv = 1'b0; cyc(2);
    chk("R4 short glitch", 3'b111, 3'b000, 1'b1, 1'b0);
    oc_pfc = 1'b1; cyc(8);
    chk("R3 pfc trip", 3'b000, 3'b000, 1'b0, 1'b1);
    oc_pfc = 1'b0; cyc(10);
    chk("R5 pulse held", 3'b000, 3'b000, 1'b0, 1'b1);
    oc_inv = 1'b1; cyc(BLK + 1); oc_inv = 1'b0; cyc(15);
    chk("R5 retrigger", 3'b000, 3'b000, 1'b0, 1'b1);
    cyc(12);
    chk("R5 auto release", 3'b111, 3'b000, 1'b1, 1'b0);
    uv_boot = 3'b010; cyc(2);
    chk("R7 boot uv", 3'b101, 3'b000, 1'b1, 1'b0);
    uv_boot = 3'b000; uv_supply = 1'b1; cyc(3);
    chk("R6 supply uv", 3'b000, 3'b000, 1'b0, 1'b1);
    uv_supply = 1'b0; cyc(3);
    chk("R8 after uv", 3'b000, 3'b000, 1'b1, 1'b0);
    hi_cmd = 3'b110; lo_cmd = 3'b001; cyc(2);
    chk("R8 partial arm", 3'b000, 3'b001, 1'b1, 1'b0);
    hi_cmd = 3'b111; lo_cmd = 3'b000; cyc(2);
    chk("R8 one armed", 3'b001, 3'b000, 1'b1, 1'b0);
    en_pin = 1'b0; cyc(2);
    chk("R9 enable low", 3'b000, 3'b000, 1'b0, 1'b0);
    en_pin = 1'b1;
    burst_i = 0; burst_p = 0; burst_u = 0;
    for (int k = 0; k < 3000; k++) begin
      hi_cmd  = NPH'($urandom);
      lo_cmd  = NPH'($urandom);
      pfc_cmd = 1'($urandom);
      uv_boot = (($urandom % 8) == 0) ? NPH'($urandom) : '0;
      en_pin  = (($urandom % 30) != 0);
      if (burst_i == 0 && ($urandom % 25) == 0) burst_i = 1 + $urandom % (2 * BLK);
      if (burst_p == 0 && ($urandom % 40) == 0) burst_p = 1 + $urandom % (2 * BLK);
      if (burst_u == 0 && ($urandom % 150) == 0) burst_u = 1 + $urandom % 6;
      oc_inv = (burst_i > 0); if (burst_i > 0) burst_i--;
      oc_pfc = (burst_p > 0); if (burst_p > 0) burst_p--;
      uv_supply = (burst_u > 0); if (burst_u > 0) burst_u--;
      cyc(1);
    end
    done = 1'b1;
    summary();
  end
endmodule